// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is an eight-stage register with four operations: shift toward the high end, shift toward the low end, parallel load and hold. Its parallel input and parallel output share one bidirectional pin group. Inside the chip that group is modelled as three signals: an input bus, an output bus and a single drive enable. A tri-state buffer at the pad ring can be built from these signals. Two serial inputs feed the end stages. Two serial taps show the end stages at all times, so several registers can be chained.

Selecting parallel load releases the shared port so that external data can be placed on it. This happens whatever the two active-low output enables say. Outside load, the port is driven only when both enables are low. The port enables never affect the register. Shifting, loading and clearing go on whether or not the port is driven. A synchronous active-low clear takes priority over every mode. A separate asynchronous chip reset, with a synchronized release, puts the register into a known state at power-up.

Top module: `usr_shift_io`

## Requirements
- R1: With {sel2,sel1} = 2'b11 (load), the value on io_in is stored into the register on the next rising clock edge.
- R2: While sel1 and sel2 are both high, io_oe is 0, even when oe1_n and oe2_n are both low.
- R3: Outside load mode, io_oe is 1 exactly when oe1_n and oe2_n are both 0.
- R4: io_out always equals the register contents, bit 0 being stage A and bit 7 stage H. A low io_oe does not stop shifting, loading or clearing.
- R5: When clr_n is low at a rising edge, every stage becomes 0, whatever the mode, serial and parallel inputs are.
- R6: With {sel2,sel1} = 2'b01 (shift right), ser_r enters bit 0 and every bit i moves to bit i+1.
- R7: With {sel2,sel1} = 2'b10 (shift left), ser_l enters bit 7 and every bit i moves to bit i-1.
- R8: With {sel2,sel1} = 2'b00 (hold), every stage keeps its value across the clock edge.
- R9: q_first always equals bit 0 and q_last always equals bit 7, whatever the enables and the mode.
- R10: While rst_n is low, the register reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low chip reset, release synchronized |
| clr_n | input | 1 | Synchronous active-low clear, highest priority |
| sel1 | input | 1 | Mode select, low bit |
| sel2 | input | 1 | Mode select, high bit |
| oe1_n | input | 1 | Active-low output enable 1 |
| oe2_n | input | 1 | Active-low output enable 2 |
| ser_r | input | 1 | Serial input into stage A for shift right |
| ser_l | input | 1 | Serial input into stage H for shift left |
| io_in | input | 8 | Shared port, value received from the pins |
| io_out | output | 8 | Shared port, value to drive onto the pins (register contents) |
| io_oe | output | 1 | Drive enable for the shared port |
| q_first | output | 1 | Stage A serial tap |
| q_last | output | 1 | Stage H serial tap |

## Verification
The case hardest to reach is a load request while both output enables are low. The port must float at that moment, even though the enables alone would ask for it to be driven. In the same group is a clear that arrives together with a load, where the clear must win. Random stimulus picks each of these combinations only now and then, so the bench forces them in a directed opening phase. After that comes a long random run in which every cycle is checked against a bench model, with enables that are often high, to show that the register keeps working behind a floating port.

// File: rtl/usr_pkg.sv
package usr_pkg;

  // Mode code is {sel2, sel1}
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;

endpackage

// File: rtl/usr_rst_sync.sv
module usr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/usr_ctrl.sv
module usr_ctrl
  import usr_pkg::*;
(
  input  logic      sel1,
  input  logic      sel2,
  input  logic      oe1_n,
  input  logic      oe2_n,
  output usr_mode_e mode_o,
  output logic      port_oe_o
);

  logic load_sel;
  logic en_pair;

  always_comb begin
    mode_o    = usr_mode_e'({sel2, sel1});
    load_sel  = sel1 & sel2;
    en_pair   = ~oe1_n & ~oe2_n;
    // the port floats during load so external data can be captured
    port_oe_o = en_pair & ~load_sel;
  end

endmodule

// File: rtl/usr_cell.sv
module usr_cell
  import usr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr_n,
  input  usr_mode_e mode,
  input  logic      from_lo,
  input  logic      from_hi,
  input  logic      par_d,
  output logic      q
);

  logic q_r;
  logic d_nxt;
  logic cken;

  // next-state
  always_comb begin
    d_nxt = q_r;
    unique case (mode)
      MODE_HOLD: d_nxt = q_r;
      MODE_SHR:  d_nxt = from_lo;
      MODE_SHL:  d_nxt = from_hi;
      MODE_LOAD: d_nxt = par_d;
    endcase
    if (!clr_n) d_nxt = 1'b0;
    cken = ~clr_n | (mode != MODE_HOLD);
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= 1'b0;
    else if (cken) q_r <= d_nxt;
  end

  assign q = q_r;

  p_clr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> !q_r);

  p_hold_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && mode == MODE_HOLD) |=> $stable(q_r));

endmodule

// File: rtl/usr_shift_io.sv
module usr_shift_io
  import usr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             sel1,
  input  logic             sel2,
  input  logic             oe1_n,
  input  logic             oe2_n,
  input  logic             ser_r,
  input  logic             ser_l,
  input  logic [WIDTH-1:0] io_in,
  output logic [WIDTH-1:0] io_out,
  output logic             io_oe,
  output logic             q_first,
  output logic             q_last
);

  localparam int MSB = WIDTH - 1;

  logic             rst_sync_n;
  usr_mode_e        mode;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] lo_src;
  logic [WIDTH-1:0] hi_src;

  usr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  usr_ctrl u_ctrl (
    .sel1      (sel1),
    .sel2      (sel2),
    .oe1_n     (oe1_n),
    .oe2_n     (oe2_n),
    .mode_o    (mode),
    .port_oe_o (io_oe)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_lo_end
      assign lo_src[i] = ser_r;
    end else begin : g_lo_mid
      assign lo_src[i] = stage_q[i-1];
    end
    if (i == MSB) begin : g_hi_end
      assign hi_src[i] = ser_l;
    end else begin : g_hi_mid
      assign hi_src[i] = stage_q[i+1];
    end

    usr_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .clr_n   (clr_n),
      .mode    (mode),
      .from_lo (lo_src[i]),
      .from_hi (hi_src[i]),
      .par_d   (io_in[i]),
      .q       (stage_q[i])
    );
  end

  assign io_out  = stage_q;
  assign q_first = stage_q[0];
  assign q_last  = stage_q[MSB];

  p_load_capture_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && sel1 && sel2) |=> io_out == $past(io_in));

  p_load_float_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel1 && sel2) |-> !io_oe);

  p_drive_pair_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!(sel1 && sel2) && !oe1_n && !oe2_n) |-> io_oe);

  p_shift_right_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && sel1 && !sel2) |=> io_out == {$past(io_out[MSB-1:0]), $past(ser_r)});

  p_shift_left_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && !sel1 && sel2) |=> io_out == {$past(ser_l), $past(io_out[MSB:1])});

endmodule

// File: tb/usr_shift_io_tb_top.sv
module usr_shift_io_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n, clr_n, sel1, sel2, oe1_n, oe2_n, ser_r, ser_l;
  logic [W-1:0] io_in;
  logic [W-1:0] io_out;
  logic         io_oe, q_first, q_last;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [W-1:0] model;

  always #4 clk = ~clk;  // 125 MHz

  usr_shift_io #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sel1(sel1), .sel2(sel2),
    .oe1_n(oe1_n), .oe2_n(oe2_n), .ser_r(ser_r), .ser_l(ser_l),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .q_first(q_first), .q_last(q_last)
  );

  function automatic logic [W-1:0] next_val(logic [W-1:0] cur, logic s1, logic s2,
                                            logic sr, logic sl, logic clr,
                                            logic [W-1:0] pin);
    if (!clr) return '0;
    case ({s2, s1})
      2'b00:   return cur;
      2'b01:   return {cur[W-2:0], sr};
      2'b10:   return {sl, cur[W-1:1]};
      default: return pin;
    endcase
  endfunction

  function automatic logic exp_oe(logic s1, logic s2, logic e1, logic e2);
    return !(s1 && s2) && !e1 && !e2;
  endfunction

  function automatic string mode_tag(logic s1, logic s2, logic clr);
    if (!clr) return "R5 clear";
    case ({s2, s1})
      2'b00:   return "R8 hold";
      2'b01:   return "R6 shift right";
      2'b10:   return "R7 shift left";
      default: return "R1 load";
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(logic s1, logic s2, logic e1, logic e2, logic sr, logic sl,
                      logic clr, logic [W-1:0] pin);
    logic [W-1:0] exp;
    sel1 = s1; sel2 = s2; oe1_n = e1; oe2_n = e2;
    ser_r = sr; ser_l = sl; clr_n = clr; io_in = pin;
    #1;
    check((s1 && s2) ? "R2 port floats in load" : "R3 port enable",
          W'(io_oe), W'(exp_oe(s1, s2, e1, e2)));
    exp = next_val(model, s1, s2, sr, sl, clr, pin);
    @(posedge clk);
    @(negedge clk);
    check(mode_tag(s1, s2, clr), io_out, exp);
    if (e1 || e2) check("R4 works while port floats", io_out, exp);
    check("R9 serial taps", W'({q_last, q_first}), W'({exp[W-1], exp[0]}));
    model = exp;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c3b_5a77));
    rst_n = 1'b0; clr_n = 1'b1; sel1 = 1'b1; sel2 = 1'b1;
    oe1_n = 1'b0; oe2_n = 1'b0; ser_r = 1'b1; ser_l = 1'b1; io_in = 8'hFF;
    model = '0;
    repeat (3) @(negedge clk);
    check("R10 reset value", io_out, '0);
    check("R10 reset taps", W'({q_last, q_first}), '0);
    sel1 = 1'b0; sel2 = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 after release", io_out, '0);

    // directed corner cases
    step(1, 1, 0, 0, 0, 0, 1, 8'hA5);   // load with both enables low: port must float
    step(0, 0, 0, 0, 1, 1, 1, 8'h00);   // hold, port driven
    step(1, 0, 1, 0, 1, 0, 1, 8'h3C);   // shift right, port disabled
    step(1, 0, 0, 1, 0, 0, 1, 8'h3C);
    step(0, 1, 1, 1, 1, 0, 1, 8'hC3);   // shift left, port disabled
    step(0, 1, 0, 0, 0, 1, 1, 8'hC3);
    step(1, 1, 0, 0, 0, 0, 0, 8'hFF);   // clear beats load
    step(1, 1, 1, 1, 0, 0, 1, 8'h81);
    step(0, 0, 1, 0, 0, 0, 0, 8'h7E);   // clear in hold mode with port off
    for (int k = 0; k < W + 1; k++) step(1, 0, 0, 0, 1, 0, 1, 8'h00);  // fill ones
    for (int k = 0; k < W + 1; k++) step(0, 1, 0, 0, 0, 0, 1, 8'hFF);  // drain

    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(1'($urandom), 1'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0,
           1'($urandom), 1'($urandom), r != 4'd0, W'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule